// File: doc/BRIEF.md
# Framing Byte Error Injector

This block sits in the transmit byte path of an STS-12 style framed stream, one byte per clock, and deliberately corrupts the A1/A2 framing bytes so that a far-end receiver's frame alignment logic can be tested. A frame-start marker accompanies the first byte of every frame. The first twelve bytes of a frame are taken as A1 bytes and the next twelve as A2 bytes.

Software programs two replacement byte values and a frame count, then raises a command bit. The rising edge arms a run. Starting at the next frame start, every A1 byte of the following frames is replaced with the A1 replacement value and every A2 byte with the A2 replacement value, for as many consecutive frames as the count asks. After the run the stream passes through untouched. A busy output shows that a run is armed or in progress. The command bit has to be lowered and raised again to start another run.

Top module: `frame_err_inject`

## Requirements
- R1: While rst_ni is low, data_o, sof_o and busy_o are all 0.
- R2: sof_o and every byte that is not replaced appear on the outputs exactly one clock after they are presented on sof_i/data_i, whether or not a run is active.
- R3: In a corrupted frame, the byte presented with sof_i=1 and the 11 bytes after it leave as a1_val_i, and the next 12 bytes leave as a2_val_i. The replacement value is taken from the input in the cycle the byte is presented.
- R4: A run corrupts exactly the number of consecutive frames given by nframes_i in the cycle of the rising edge. Later changes to nframes_i do not affect a run already armed.
- R5: Only a 0-to-1 transition of cmd_i starts a run. Holding cmd_i high after a run has finished corrupts nothing more.
- R6: A rising edge of cmd_i while busy_o is high is ignored and neither extends nor restarts the run.
- R7: A rising edge with nframes_i equal to 0 corrupts nothing, and busy_o stays low.
- R8: busy_o rises one clock after an accepted rising edge. It falls on the clock edge that puts the last replaced A2 byte of the final frame on data_o.
- R9: Corruption begins at the first frame start strictly after the cycle of the rising edge. An edge in the middle of a frame, or in the same cycle as sof_i, waits for the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Transmit byte in |
| sof_i | input | 1 | High with the first byte of a frame |
| cmd_i | input | 1 | Insert command; its rising edge arms a run |
| a1_val_i | input | 8 | Replacement value for A1 bytes |
| a2_val_i | input | 8 | Replacement value for A2 bytes |
| nframes_i | input | 4 | Number of consecutive frames to corrupt |
| data_o | output | 8 | Transmit byte out, one cycle later |
| sof_o | output | 1 | Frame start, delayed one cycle |
| busy_o | output | 1 | High while a run is armed or in progress |

## Verification
The hardest situations to reach are edges that fall right on the boundaries: a command edge in the same cycle as a frame start, and a second edge, with a larger count, made while a run is still going. The stimulus places cmd_i transitions at chosen byte positions inside the frame, and changes nframes_i after the first edge, so that both the deferral to the next frame and the rejection of the late edge show up as a measured number of replaced bytes. Payload bytes keep bit 7 clear and the replacement values have it set, so every replaced byte can be seen and counted at the output.

// File: rtl/frame_inj_pkg.sv
package frame_inj_pkg;
  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_A1   = 2'd1,
    SEL_A2   = 2'd2
  } byte_sel_e;
endpackage

// File: rtl/cmd_edge_det.sv
module cmd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  output logic rise_o
);
  logic cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= 1'b0;
    else         cmd_q <= cmd_i;
  end

  assign rise_o = cmd_i & ~cmd_q;
endmodule

// File: rtl/inj_run_ctrl.sv
module inj_run_ctrl
  import frame_inj_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int N_A1  = 12,
  parameter int N_A2  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             sof_i,
  input  logic [CNT_W-1:0] nframes_i,
  output byte_sel_e        sel_o,
  output logic             busy_o
);
  localparam int HDR   = N_A1 + N_A2;
  localparam int POS_W = $clog2(HDR + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(HDR - 1);
  localparam logic [POS_W-1:0] A1_END   = POS_W'(N_A1);

  logic             busy_q, act_q;
  logic [CNT_W-1:0] rem_q;
  logic [POS_W-1:0] pos_q;
  logic             start_frm;

  assign start_frm = busy_q & sof_i & (rem_q != '0);

  always_comb begin
    if (start_frm)            sel_o = SEL_A1;
    else if (act_q && !sof_i) sel_o = (pos_q < A1_END) ? SEL_A1 : SEL_A2;
    else                      sel_o = SEL_PASS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      rem_q  <= '0;
      pos_q  <= '0;
    end else if (!busy_q) begin
      // count sampled on the accepted edge; zero count never arms
      if (rise_i && nframes_i != '0) begin
        busy_q <= 1'b1;
        rem_q  <= nframes_i;
      end
    end else if (start_frm) begin
      rem_q <= rem_q - 1'b1;
      act_q <= 1'b1;
      pos_q <= POS_W'(1);
    end else if (act_q && sof_i) begin
      // frame start inside header with nothing left: end the run
      act_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (act_q) begin
      if (pos_q == LAST_POS) begin
        act_q <= 1'b0;
        if (rem_q == '0) busy_q <= 1'b0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/byte_replace.sv
module byte_replace
  import frame_inj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sof_i,
  input  byte_sel_e         sel_i,
  input  logic [DATA_W-1:0] a1_i,
  input  logic [DATA_W-1:0] a2_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sof_o
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (sel_i)
      SEL_A1:  nxt = a1_i;
      SEL_A2:  nxt = a2_i;
      default: nxt = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      sof_o  <= 1'b0;
    end else begin
      data_o <= nxt;
      sof_o  <= sof_i;
    end
  end
endmodule

// File: rtl/frame_err_inject.sv
module frame_err_inject
  import frame_inj_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int N_A1   = 12,
  parameter int N_A2   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sof_i,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] a1_val_i,
  input  logic [DATA_W-1:0] a2_val_i,
  input  logic [CNT_W-1:0]  nframes_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sof_o,
  output logic              busy_o
);
  logic      rise;
  byte_sel_e sel;

  cmd_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .rise_o (rise)
  );

  inj_run_ctrl #(
    .CNT_W (CNT_W),
    .N_A1  (N_A1),
    .N_A2  (N_A2)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .sof_i     (sof_i),
    .nframes_i (nframes_i),
    .sel_o     (sel),
    .busy_o    (busy_o)
  );

  byte_replace #(
    .DATA_W (DATA_W)
  ) u_repl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .sof_i  (sof_i),
    .sel_i  (sel),
    .a1_i   (a1_val_i),
    .a2_i   (a2_val_i),
    .data_o (data_o),
    .sof_o  (sof_o)
  );
endmodule

// File: rtl/frame_err_inject_chk.sv
module frame_err_inject_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              sof_i,
  input logic              cmd_i,
  input logic [CNT_W-1:0]  nframes_i,
  input logic [DATA_W-1:0] data_o,
  input logic              sof_o,
  input logic              busy_o
);
  // R2
  sof_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sof_o == $past(sof_i));

  // R2
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> data_o == $past(data_i));

  // R7
  zero_count_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && nframes_i == '0) |=> !busy_o);

  // R8
  busy_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_i) && $past(nframes_i) != '0);

  // R5
  busy_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_i) |=> !busy_o);
endmodule

bind frame_err_inject frame_err_inject_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .sof_i     (sof_i),
  .cmd_i     (cmd_i),
  .nframes_i (nframes_i),
  .data_o    (data_o),
  .sof_o     (sof_o),
  .busy_o    (busy_o)
);

// File: tb/frame_err_inject_tb.sv
module frame_err_inject_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       sof_i = 1'b0;
  logic       cmd_i = 1'b0;
  logic [7:0] a1_val_i = '0;
  logic [7:0] a2_val_i = '0;
  logic [3:0] nframes_i = '0;
  logic [7:0] data_o;
  logic       sof_o;
  logic       busy_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  frame_err_inject u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .sof_i     (sof_i),
    .cmd_i     (cmd_i),
    .a1_val_i  (a1_val_i),
    .a2_val_i  (a2_val_i),
    .nframes_i (nframes_i),
    .data_o    (data_o),
    .sof_o     (sof_o),
    .busy_o    (busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: run state as frames left and header byte index
  logic [7:0] exp_data = '0, prev_in = '0;
  logic       exp_sof = 1'b0, exp_busy = 1'b0, exp_repl = 1'b0;
  logic       cmd_prev = 1'b0;
  bit         m_busy = 0, was_busy, rise;
  int         left = 0, idx = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_data = '0; exp_sof = 0; exp_busy = 0; exp_repl = 0;
      cmd_prev = 0; m_busy = 0; left = 0; idx = 0; prev_in = '0;
    end else begin
      was_busy = m_busy;
      rise = cmd_i && !cmd_prev;
      cmd_prev = cmd_i;
      exp_sof = sof_i;
      exp_repl = 1;
      if (was_busy && sof_i && left > 0) begin
        exp_data = a1_val_i; left--; idx = 1;
      end else if (idx > 0 && sof_i) begin
        idx = 0; m_busy = 0; exp_data = data_i; exp_repl = 0;
      end else if (idx > 0) begin
        exp_data = (idx < 12) ? a1_val_i : a2_val_i;
        idx++;
        if (idx == 24) begin
          idx = 0;
          if (left == 0) m_busy = 0;
        end
      end else begin
        exp_data = data_i; exp_repl = 0;
      end
      if (rise && !was_busy && nframes_i != 0) begin
        m_busy = 1; left = int'(nframes_i);
      end
      exp_busy = m_busy;
      prev_in = data_i;
    end
  end

  int repl_cnt = 0;
  bit first_seen = 0;
  bit cmp_on = 0;

  always @(negedge clk_i) begin
    if (rst_ni && cmp_on) begin
      check(data_o == exp_data, exp_repl ? "R3" : "R2", data_o, exp_data);
      check(sof_o == exp_sof, "R2", sof_o, exp_sof);
      check(busy_o == exp_busy, "R8", busy_o, exp_busy);
      if (data_o != prev_in) begin
        repl_cnt++;
        if (!first_seen) begin
          first_seen = 1;
          // R9: first replaced byte is a frame's first byte
          check(sof_o == 1'b1, "R9", sof_o, 1);
        end
      end
    end
  end

  task automatic frame(input int fl, input int cpos, input bit cval);
    for (int i = 0; i < fl; i++) begin
      @(posedge clk_i);
      #2;
      if (i == cpos) cmd_i = cval;
      data_i = 8'($urandom) & 8'h7F;
      sof_i  = (i == 0);
    end
  endtask

  task automatic start_scn();
    repl_cnt = 0;
    first_seen = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    // R1
    check(data_o == 8'h00, "R1", data_o, 0);
    check(sof_o == 1'b0, "R1", sof_o, 0);
    check(busy_o == 1'b0, "R1", busy_o, 0);
    rst_ni = 1'b1;
    cmp_on = 1;

    // R2: plain pass-through
    start_scn();
    repeat (2) frame(40, -1, 0);
    check(repl_cnt == 0, "R2", repl_cnt, 0);

    // R4/R9: one frame, edge mid-frame
    a1_val_i = 8'hF6; a2_val_i = 8'hA8; nframes_i = 4'd1;
    start_scn();
    frame(40, 10, 1);
    frame(40, 20, 0);
    repeat (2) frame(40, -1, 0);
    check(repl_cnt == 24, "R4", repl_cnt, 24);

    // R9: edge in the same cycle as sof waits for the next frame
    nframes_i = 4'd3;
    start_scn();
    frame(40, 0, 1);
    repeat (5) frame(40, -1, 1);
    check(repl_cnt == 72, "R4", repl_cnt, 72);

    // R5: cmd held high corrupts nothing more
    start_scn();
    repeat (3) frame(40, -1, 1);
    check(repl_cnt == 0, "R5", repl_cnt, 0);
    frame(40, 5, 0);

    // R6: second edge during run, with bigger count, is ignored
    nframes_i = 4'd2; a1_val_i = 8'h9C; a2_val_i = 8'hC3;
    start_scn();
    frame(40, 5, 1);
    nframes_i = 4'd15;
    frame(40, 30, 0);
    frame(40, 3, 1);
    repeat (4) frame(40, -1, 1);
    check(repl_cnt == 48, "R6", repl_cnt, 48);
    check(busy_o == 1'b0, "R6", busy_o, 0);

    // R7: zero count
    nframes_i = 4'd0;
    frame(40, 2, 0);
    start_scn();
    frame(40, 7, 1);
    repeat (3) frame(40, -1, 1);
    check(repl_cnt == 0, "R7", repl_cnt, 0);
    check(busy_o == 1'b0, "R7", busy_o, 0);

    // R4: maximum count on short frames, new values
    frame(30, 1, 0);
    nframes_i = 4'd15; a1_val_i = 8'hFF; a2_val_i = 8'h80;
    start_scn();
    frame(30, 12, 1);
    repeat (17) frame(30, -1, 1);
    check(repl_cnt == 360, "R4", repl_cnt, 360);

    cmp_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule